// File: doc/BRIEF.md
# Processor Clock Throttle Duty Controller

This block drives a gating signal that puts a processor core into suspend for part of every throttle period. Time is counted in cycles of the bus clock that runs the block. Software programs three fields through a small word-wide register port: a start delay, a scale factor and a clock value. A one-cycle strobe reports that the idle-level trigger register was read, and that strobe arms the sequence. The block first waits for the start delay. It then alternates between an active period, with the gating output low, and a suspend period, with the gating output high.

The start delay lasts sixteen times the delay field. The active period lasts sixteen times the scale factor times the clock value. The suspend period lasts sixteen times the scale factor times (15 minus the clock value). A status bit shows that the sequence is armed. Software can abort the sequence by writing a one to that bit. Any line of the wake-event bundle also stops the sequence; the bundle carries the non-maskable interrupt, the maskable interrupt, the two management interrupts, the debug interrupt and system sleep. A period whose computed length is zero is skipped. Period lengths are captured at each period boundary.

Top module: `throttle_duty_ctrl`

## Requirements
- R1: After a synchronous reset, `suspend_out` is low, the status bit is 0 and every register field reads 0.
- R2: Reads return data one cycle after the address is presented. Address 0 holds the start delay in bits [11:0] and the status bit in bit 12. Address 1 holds the scale factor in bits [7:0]. Address 2 holds the clock value in bits [3:0]. Every other bit reads 0, and address 3 reads 0.
- R3: A `trig_rd` pulse while the block is idle sets the status bit and begins a start delay of delay×16 cycles with `suspend_out` low. A delay of 0 skips this wait.
- R4: After the delay, active periods of scale×clkval×16 cycles (`suspend_out` low) alternate with suspend periods of scale×(15−clkval)×16 cycles (`suspend_out` high).
- R5: With delay 3, scale 3 and clkval 5, `suspend_out` stays low for 48+240 cycles, then runs 480 high, 240 low, 480 high.
- R6: A zero-length period is skipped. Clkval 15 never suspends. Scale 0 never suspends. Clkval 0 with a nonzero scale suspends permanently once the delay ends.
- R7: Writing a 1 to status bit 12 clears the status bit and drops `suspend_out` on the next cycle. This write has no effect while the block is idle.
- R8: When any bit of `wake_evt` is high, the status bit clears and `suspend_out` is low on the next cycle.
- R9: A wake event in the same cycle as `trig_rd` wins, and the block stays idle.
- R10: A period length is captured when the period begins. A field written during a period affects only later periods.
- R11: The status bit is 1 exactly while the sequencer is not idle, and `suspend_out` is high only while the status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every count is in these cycles |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address for reads and writes |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered read data for `cfg_addr` |
| trig_rd | input | 1 | Pulse marking a read of the idle-level trigger register |
| wake_evt | input | 6 | Wake events: NMI, IRQ, two management interrupts, debug interrupt, sleep |
| suspend_out | output | 1 | High while the core should be suspended |

## Verification
The bench builds the block with its default widths: a 12-bit delay, an 8-bit scale, a 4-bit clock value and a multiplier of 16. With these widths every period the bench uses is a few hundred cycles. That lets it measure exact run lengths of `suspend_out`, including the full 48+240/480 example, in a short run. Small field values such as scale 1 bring the zero-length skip cases into reach: clock value 0 and 15, and scale 0. They also allow a mid-period register write, whose effect must appear only in the next period.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_ACT   = 2'd2,
    ST_SUS   = 2'd3
  } thr_state_e;
endpackage

// File: rtl/thr_regs.sv
module thr_regs #(
  parameter int DLY_W  = 12,
  parameter int SCL_W  = 8,
  parameter int CV_W   = 4,
  parameter int EVT_N  = 6,
  parameter int DATA_W = 16,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              trig_rd,
  input  logic [EVT_N-1:0]  wake_evt,
  output logic [DLY_W-1:0]  dly_q,
  output logic [SCL_W-1:0]  scl_q,
  output logic [CV_W-1:0]   cv_q,
  output logic              status_q,
  output logic              kill,
  output logic              start
);
  localparam int STAT_BIT = DLY_W;

  logic wr_dly, wr_scl, wr_cv, abort_wr;
  logic [DATA_W-1:0] rd_c;

  assign wr_dly   = cfg_wr && (cfg_addr == AW'(0));
  assign wr_scl   = cfg_wr && (cfg_addr == AW'(1));
  assign wr_cv    = cfg_wr && (cfg_addr == AW'(2));
  assign abort_wr = wr_dly && cfg_wdata[STAT_BIT];
  assign kill     = (|wake_evt) || abort_wr;
  assign start    = trig_rd && !status_q && !kill;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q    <= '0;
      scl_q    <= '0;
      cv_q     <= '0;
      status_q <= 1'b0;
    end else begin
      if (wr_dly) dly_q <= cfg_wdata[DLY_W-1:0];
      if (wr_scl) scl_q <= cfg_wdata[SCL_W-1:0];
      if (wr_cv)  cv_q  <= cfg_wdata[CV_W-1:0];
      if (kill)       status_q <= 1'b0;
      else if (start) status_q <= 1'b1;
    end
  end

  always_comb begin
    rd_c = '0;
    case (cfg_addr)
      AW'(0): begin
        rd_c[DLY_W-1:0] = dly_q;
        rd_c[STAT_BIT]  = status_q;
      end
      AW'(1): rd_c[SCL_W-1:0] = scl_q;
      AW'(2): rd_c[CV_W-1:0]  = cv_q;
      default: rd_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_c;
  end
endmodule

// File: rtl/thr_len.sv
module thr_len #(
  parameter int DLY_W = 12,
  parameter int SCL_W = 8,
  parameter int CV_W  = 4,
  parameter int SHIFT = 4,
  parameter int CNT_W = 16
) (
  input  logic [DLY_W-1:0] dly,
  input  logic [SCL_W-1:0] scl,
  input  logic [CV_W-1:0]  cv,
  output logic [CNT_W-1:0] dly_len,
  output logic [CNT_W-1:0] act_len,
  output logic [CNT_W-1:0] sus_len
);
  logic [CV_W-1:0] cv_inv;

  // the suspend share is the complement of the clock value within its field
  assign cv_inv  = ~cv;
  assign dly_len = CNT_W'(dly) << SHIFT;
  assign act_len = (CNT_W'(scl) * CNT_W'(cv)) << SHIFT;
  assign sus_len = (CNT_W'(scl) * CNT_W'(cv_inv)) << SHIFT;
endmodule

// File: rtl/thr_seq.sv
module thr_seq #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kill,
  input  logic              start,
  input  logic [CNT_W-1:0]  dly_len,
  input  logic [CNT_W-1:0]  act_len,
  input  logic [CNT_W-1:0]  sus_len,
  output thr_pkg::thr_state_e state,
  output logic [CNT_W-1:0]  cnt,
  output logic              suspend_out
);
  import thr_pkg::*;

  thr_state_e nxt, st_a, st_s;
  logic [CNT_W-1:0] ncnt, cnt_a, cnt_s;
  logic act_nz, sus_nz;

  assign act_nz = (act_len != '0);
  assign sus_nz = (sus_len != '0);

  // entry choices: active first (after delay or suspend), suspend first (after active)
  always_comb begin
    if (act_nz) begin
      st_a = ST_ACT; cnt_a = act_len - 1'b1;
    end else if (sus_nz) begin
      st_a = ST_SUS; cnt_a = sus_len - 1'b1;
    end else begin
      st_a = ST_ACT; cnt_a = '0;
    end
    if (sus_nz) begin
      st_s = ST_SUS; cnt_s = sus_len - 1'b1;
    end else if (act_nz) begin
      st_s = ST_ACT; cnt_s = act_len - 1'b1;
    end else begin
      st_s = ST_ACT; cnt_s = '0;
    end
  end

  always_comb begin
    nxt  = state;
    ncnt = cnt;
    if (kill) begin
      nxt  = ST_IDLE;
      ncnt = '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          if (dly_len != '0) begin
            nxt  = ST_DELAY;
            ncnt = dly_len - 1'b1;
          end else begin
            nxt  = st_a;
            ncnt = cnt_a;
          end
        end
        ST_DELAY, ST_SUS: begin
          if (cnt == '0) begin
            nxt  = st_a;
            ncnt = cnt_a;
          end else ncnt = cnt - 1'b1;
        end
        ST_ACT: begin
          if (cnt == '0) begin
            nxt  = st_s;
            ncnt = cnt_s;
          end else ncnt = cnt - 1'b1;
        end
        default: begin
          nxt  = ST_IDLE;
          ncnt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      suspend_out <= 1'b0;
    end else begin
      state       <= nxt;
      cnt         <= ncnt;
      suspend_out <= (nxt == ST_SUS);
    end
  end
endmodule

// File: rtl/throttle_duty_ctrl.sv
module throttle_duty_ctrl #(
  parameter int DLY_W  = 12,
  parameter int SCL_W  = 8,
  parameter int CV_W   = 4,
  parameter int SHIFT  = 4,
  parameter int EVT_N  = 6,
  parameter int DATA_W = 16,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              trig_rd,
  input  logic [EVT_N-1:0]  wake_evt,
  output logic              suspend_out
);
  localparam int PROD_W = SCL_W + CV_W + SHIFT;
  localparam int DLEN_W = DLY_W + SHIFT;
  localparam int CNT_W  = (PROD_W > DLEN_W) ? PROD_W : DLEN_W;

  logic [DLY_W-1:0] dly_q;
  logic [SCL_W-1:0] scl_q;
  logic [CV_W-1:0]  cv_q;
  logic             status_q, kill, start;
  logic [CNT_W-1:0] dly_len, act_len, sus_len, cnt;
  thr_pkg::thr_state_e state;

  thr_regs #(
    .DLY_W(DLY_W), .SCL_W(SCL_W), .CV_W(CV_W),
    .EVT_N(EVT_N), .DATA_W(DATA_W), .AW(AW)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig_rd(trig_rd),
    .wake_evt(wake_evt), .dly_q(dly_q), .scl_q(scl_q), .cv_q(cv_q),
    .status_q(status_q), .kill(kill), .start(start)
  );

  thr_len #(
    .DLY_W(DLY_W), .SCL_W(SCL_W), .CV_W(CV_W), .SHIFT(SHIFT), .CNT_W(CNT_W)
  ) u_len (
    .dly(dly_q), .scl(scl_q), .cv(cv_q),
    .dly_len(dly_len), .act_len(act_len), .sus_len(sus_len)
  );

  thr_seq #(
    .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .kill(kill), .start(start),
    .dly_len(dly_len), .act_len(act_len), .sus_len(sus_len),
    .state(state), .cnt(cnt), .suspend_out(suspend_out)
  );
endmodule

// File: rtl/throttle_duty_chk.sv
module throttle_duty_chk #(
  parameter int DLY_W  = 12,
  parameter int EVT_N  = 6,
  parameter int DATA_W = 16,
  parameter int AW     = 2,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [AW-1:0]     cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              trig_rd,
  input logic [EVT_N-1:0]  wake_evt,
  input logic              suspend_out,
  input logic              status_q,
  input thr_pkg::thr_state_e state,
  input logic [CNT_W-1:0]  cnt
);
  import thr_pkg::*;

  logic abort_w;
  assign abort_w = cfg_wr && (cfg_addr == AW'(0)) && cfg_wdata[DLY_W];

  assert_idle_status_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) == !status_q);

  assert_suspend_armed_R11: assert property (@(posedge clk) disable iff (rst)
    suspend_out |-> status_q);

  assert_wake_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (|wake_evt) |=> (!suspend_out && !status_q));

  assert_abort_drops_R7: assert property (@(posedge clk) disable iff (rst)
    abort_w |=> (!suspend_out && !status_q));

  assert_wake_beats_trig_R9: assert property (@(posedge clk) disable iff (rst)
    (trig_rd && (|wake_evt)) |=> (state == ST_IDLE));

  assert_trig_arms_R3: assert property (@(posedge clk) disable iff (rst)
    (trig_rd && !status_q && !(|wake_evt) && !abort_w) |=> status_q);

  assert_count_steps_R10: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && cnt != '0 && !(|wake_evt) && !abort_w)
      |=> (state == $past(state) && cnt == $past(cnt) - 1'b1));
endmodule

bind throttle_duty_ctrl throttle_duty_chk #(
  .DLY_W(DLY_W), .EVT_N(EVT_N), .DATA_W(DATA_W), .AW(AW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .trig_rd(trig_rd), .wake_evt(wake_evt),
  .suspend_out(suspend_out), .status_q(status_q), .state(state), .cnt(cnt)
);

// File: tb/throttle_duty_ctrl_test.sv
`timescale 1ns/1ps
module throttle_duty_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic [15:0] cfg_rdata;
  logic        trig_rd = 1'b0;
  logic [5:0]  wake_evt = 6'd0;
  logic        suspend_out;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  throttle_duty_ctrl uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig_rd(trig_rd),
    .wake_evt(wake_evt), .suspend_out(suspend_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = 16'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic pulse_trig();
    trig_rd = 1'b1;
    @(negedge clk);
    trig_rd = 1'b0;
  endtask

  task automatic count_run(input logic lvl, output int n);
    n = 0;
    while (suspend_out == lvl && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic hold_check(input logic lvl, input int cycles, output int viol);
    viol = 0;
    for (int i = 0; i < cycles; i++) begin
      if (suspend_out != lvl) viol++;
      @(negedge clk);
    end
  endtask

  task automatic do_abort();
    wr(2'd0, 16'h1000);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk(suspend_out == 1'b0, "R1 suspend", int'(suspend_out), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 16'd0, "R1 field", int'(d), 0);
    end
  endtask

  task automatic t_regmap();
    logic [15:0] d;
    wr(2'd0, 16'hFFFF);
    chk(suspend_out == 1'b0, "R7 idle abort", int'(suspend_out), 0);
    rd(2'd0, d);
    chk(d == 16'h0FFF, "R2 addr0 (R7 idle)", int'(d), 16'h0FFF);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, d);
    chk(d == 16'h00FF, "R2 addr1", int'(d), 16'h00FF);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d);
    chk(d == 16'h000F, "R2 addr2", int'(d), 16'h000F);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, d);
    chk(d == 16'h0000, "R2 addr3", int'(d), 0);
  endtask

  task automatic t_example();
    int n;
    logic [15:0] d;
    wr(2'd0, 16'd3); wr(2'd1, 16'd3); wr(2'd2, 16'd5);
    pulse_trig();
    count_run(1'b0, n); chk(n == 288, "R5 R3 delay+active", n, 288);
    count_run(1'b1, n); chk(n == 480, "R5 R4 suspend", n, 480);
    count_run(1'b0, n); chk(n == 240, "R5 R4 active", n, 240);
    rd(2'd0, d);
    chk(d[12] == 1'b1, "R11 status armed", int'(d[12]), 1);
    wr(2'd0, 16'h1003);
    chk(suspend_out == 1'b0, "R7 abort suspend", int'(suspend_out), 0);
    rd(2'd0, d);
    chk(d[12] == 1'b0, "R7 abort status", int'(d[12]), 0);
  endtask

  task automatic t_cv15();
    int v;
    logic [15:0] d;
    wr(2'd0, 16'd0); wr(2'd1, 16'd1); wr(2'd2, 16'd15);
    pulse_trig();
    hold_check(1'b0, 2000, v);
    chk(v == 0, "R6 clkval 15 no suspend", v, 0);
    rd(2'd0, d);
    chk(d[12] == 1'b1, "R6 clkval 15 armed", int'(d[12]), 1);
    do_abort();
  endtask

  task automatic t_cv0();
    int n, v;
    wr(2'd0, 16'd1); wr(2'd1, 16'd1); wr(2'd2, 16'd0);
    pulse_trig();
    count_run(1'b0, n); chk(n == 16, "R6 clkval 0 delay", n, 16);
    hold_check(1'b1, 1000, v);
    chk(v == 0, "R6 clkval 0 always suspended", v, 0);
    do_abort();
  endtask

  task automatic t_scale0();
    int v;
    wr(2'd0, 16'd2); wr(2'd1, 16'd0); wr(2'd2, 16'd5);
    pulse_trig();
    hold_check(1'b0, 1000, v);
    chk(v == 0, "R6 scale 0 no suspend", v, 0);
    do_abort();
  endtask

  task automatic t_wake();
    int n;
    logic [15:0] d;
    wr(2'd0, 16'd0); wr(2'd1, 16'd1); wr(2'd2, 16'd1);
    for (int b = 0; b < 6; b++) begin
      pulse_trig();
      count_run(1'b0, n); chk(n == 16, "R4 R3 no delay active", n, 16);
      wake_evt = 6'(1 << b);
      @(negedge clk);
      wake_evt = 6'd0;
      chk(suspend_out == 1'b0, "R8 wake suspend", b, 0);
      rd(2'd0, d);
      chk(d[12] == 1'b0, "R8 wake status", int'(d[12]), 0);
    end
  endtask

  task automatic t_wake_trig();
    int v;
    logic [15:0] d;
    wr(2'd0, 16'd0); wr(2'd1, 16'd1); wr(2'd2, 16'd1);
    trig_rd = 1'b1; wake_evt = 6'b000100;
    @(negedge clk);
    trig_rd = 1'b0; wake_evt = 6'd0;
    hold_check(1'b0, 300, v);
    chk(v == 0, "R9 wake wins no suspend", v, 0);
    rd(2'd0, d);
    chk(d[12] == 1'b0, "R9 wake wins status", int'(d[12]), 0);
  endtask

  task automatic t_latch();
    int n;
    wr(2'd0, 16'd0); wr(2'd1, 16'd1); wr(2'd2, 16'd1);
    pulse_trig();
    count_run(1'b0, n); chk(n == 16, "R10 first active", n, 16);
    wr(2'd2, 16'd2);
    count_run(1'b1, n); n = n + 1;
    chk(n == 224, "R10 current suspend kept", n, 224);
    count_run(1'b0, n); chk(n == 32, "R10 next active", n, 32);
    count_run(1'b1, n); chk(n == 208, "R10 next suspend", n, 208);
    do_abort();
  endtask

  initial begin
    #(8 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_example();
    t_cv15();
    t_cv0();
    t_scale0();
    t_wake();
    t_wake_trig();
    t_latch();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule